// File: doc/BRIEF.md
# Pinned-Entry Translation Lookaside Cache

This block is a small, fully associative cache of address translations. Each entry pairs a virtual page number with a physical frame number. A lookup compares the presented page number against every valid entry at once. One clock later it reports whether a match was found and, if so, the frame number of the matching entry.

When a lookup misses, the surrounding logic resolves the translation and writes it back through the refill port. The fill lands in a free entry when one exists. Otherwise it overwrites the least recently used entry among those that are not pinned. Pinned entries hold translations that must stay resident, such as kernel mappings, and replacement never evicts them. A flush input invalidates every unpinned entry in a single cycle and leaves pinned entries alone.

Top module: `tlb_pin_cache`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_pfn` and `fill_err` are all 0.
- R2: `rsp_valid` equals the previous cycle's `lookup_valid`. `rsp_hit` is 1 only if that lookup's page number matched a valid entry. `rsp_pfn` carries that entry's frame number on a hit and 0 otherwise.
- R3: An accepted fill whose page number is not already present is written into the lowest-indexed invalid entry if one exists, and later lookups of that page hit with the filled frame.
- R4: A fill whose page number matches a valid entry rewrites that entry's frame and pin flag in place, so no page is ever held twice.
- R5: Every accepted fill and every lookup hit make the touched entry the most recently used. When no entry is invalid, a new page replaces the valid unpinned entry touched longest ago.
- R6: An entry whose pin flag is 1 is never chosen for replacement.
- R7: If every entry is valid and pinned, a fill of a new page is dropped and the contents are unchanged. `fill_err` is 1 for exactly the one cycle after that fill.
- R8: While `flush` is 1, all unpinned entries become invalid at the next edge, pinned entries keep their contents, and a fill in the same cycle is dropped without raising `fill_err`.
- R9: A lookup in the same cycle as a fill sees the contents from before that fill. When a fill is accepted in that cycle, only the filled entry is made most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_vpn | input | VPN_W | Page number to translate |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | VPN_W | Page number being installed |
| fill_pfn | input | PFN_W | Frame number being installed |
| fill_pin | input | 1 | 1 pins the installed entry |
| flush | input | 1 | Invalidate all unpinned entries |
| rsp_valid | output | 1 | Registered: a lookup was presented last cycle |
| rsp_hit | output | 1 | Registered: that lookup matched |
| rsp_pfn | output | PFN_W | Registered frame number on a hit, else 0 |
| fill_err | output | 1 | One-cycle pulse: fill dropped because all entries are pinned |

## Verification
The bench exercises a four-entry configuration. Hit-then-fill patterns show whether recency follows the touch order, because a lookup of the oldest entry just before a fill moves the victim to the next oldest entry. Fills with pin mixed in, fills of pages already held, and flushes alongside fills separate pinned survival, in-place update and flush priority. A long random stream over six page numbers then drives every mix of hits, misses, duplicates, pins and flushes against an independent timestamp-based model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Index of the lowest set bit among the first n bits of v (0 if none).
  function automatic int first_set(input logic [63:0] v, input int n);
    int idx;
    idx = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Recency rank after a touch: 0 is most recent. The entry holding rank t
  // moves to 0; younger entries age by one; older ones keep their rank.
  function automatic int rank_after_touch(input int cur, input int t);
    if (cur == t) return 0;
    else if (cur < t) return cur + 1;
    else return cur;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 8,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            valid_vec,
  input  logic [N-1:0][VPN_W-1:0] key_arr,
  input  logic [VPN_W-1:0]        probe,
  output logic [N-1:0]            match_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (key_arr[g] == probe);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_en,
  input  logic [RW-1:0]        touch_idx,
  output logic [N-1:0][RW-1:0] rank_arr
);
  logic [RW-1:0] touched_rank;
  assign touched_rank = rank_arr[touch_idx];

  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_arr[g] <= RW'(g);
      end else if (touch_en) begin
        rank_arr[g] <= RW'(tlb_pkg::rank_after_touch(int'(rank_arr[g]),
                                                     int'(touched_rank)));
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic [N-1:0]         valid_vec,
  input  logic [N-1:0]         pin_vec,
  input  logic [N-1:0][RW-1:0] rank_arr,
  output logic [RW-1:0]        victim_idx,
  output logic                 victim_ok,
  output logic                 victim_is_repl
);
  logic          free_found;
  logic [RW-1:0] free_idx;
  logic          old_found;
  logic [RW-1:0] old_idx;
  logic [RW-1:0] old_rank;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    old_found  = 1'b0;
    old_idx    = '0;
    old_rank   = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_vec[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = RW'(i);
      end
      if (valid_vec[i] && !pin_vec[i] && (!old_found || rank_arr[i] > old_rank)) begin
        old_found = 1'b1;
        old_idx   = RW'(i);
        old_rank  = rank_arr[i];
      end
    end
  end

  assign victim_idx     = free_found ? free_idx : old_idx;
  assign victim_ok      = free_found || old_found;
  assign victim_is_repl = !free_found && old_found;
endmodule

// File: rtl/tlb_pin_cache.sv
module tlb_pin_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_valid,
  input  logic [VPN_W-1:0] lookup_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_pin,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             fill_err
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            pin_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0][IW-1:0]    rank_arr;

  // Named internal events, also observed by the bound checker.
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic               lk_hit;
  logic [IW-1:0]      lk_idx;
  logic               fill_dup;
  logic [IW-1:0]      dup_idx;
  logic [IW-1:0]      vic_idx;
  logic               vic_ok;
  logic               vic_repl;
  logic               fill_go;
  logic               fill_rej;
  logic [IW-1:0]      tgt_idx;
  logic               repl_evt;
  logic               touch_en;
  logic [IW-1:0]      touch_idx;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_lookup (
    .valid_vec(valid_q), .key_arr(vpn_q), .probe(lookup_vpn), .match_vec(lk_match)
  );

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
    .valid_vec(valid_q), .key_arr(vpn_q), .probe(fill_vpn), .match_vec(fl_match)
  );

  tlb_victim #(.N(ENTRIES), .RW(IW)) u_victim (
    .valid_vec(valid_q), .pin_vec(pin_q), .rank_arr(rank_arr),
    .victim_idx(vic_idx), .victim_ok(vic_ok), .victim_is_repl(vic_repl)
  );

  assign lk_hit   = |lk_match;
  assign lk_idx   = IW'(tlb_pkg::first_set(64'(lk_match), ENTRIES));
  assign fill_dup = |fl_match;
  assign dup_idx  = IW'(tlb_pkg::first_set(64'(fl_match), ENTRIES));

  assign fill_go   = fill_valid && !flush && (fill_dup || vic_ok);
  assign fill_rej  = fill_valid && !flush && !fill_dup && !vic_ok;
  assign tgt_idx   = fill_dup ? dup_idx : vic_idx;
  assign repl_evt  = fill_go && !fill_dup && vic_repl;
  assign touch_en  = fill_go || (lookup_valid && lk_hit);
  assign touch_idx = fill_go ? tgt_idx : lk_idx;

  tlb_lru #(.N(ENTRIES), .RW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .rank_arr(rank_arr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pin_q   <= '0;
      vpn_q   <= '0;
      pfn_q   <= '0;
    end else if (flush) begin
      valid_q <= valid_q & pin_q;
    end else if (fill_go) begin
      valid_q[tgt_idx] <= 1'b1;
      pin_q[tgt_idx]   <= fill_pin;
      vpn_q[tgt_idx]   <= fill_vpn;
      pfn_q[tgt_idx]   <= fill_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      fill_err  <= 1'b0;
    end else begin
      rsp_valid <= lookup_valid;
      rsp_hit   <= lookup_valid && lk_hit;
      rsp_pfn   <= (lookup_valid && lk_hit) ? pfn_q[lk_idx] : '0;
      fill_err  <= fill_rej;
    end
  end
endmodule

// File: rtl/tlb_pin_cache_chk.sv
module tlb_pin_cache_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lookup_valid,
  input logic          fill_valid,
  input logic          flush,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          fill_err,
  input logic [N-1:0]  lk_match,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  pin_q,
  input logic          repl_evt,
  input logic [IW-1:0] vic_idx
);
  assert_hit_has_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> rsp_valid);

  assert_no_double_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_victim_not_pinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    repl_evt |-> !pin_q[vic_idx]);

  assert_err_after_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_valid));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~pin_q) == '0));

  assert_flush_keeps_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & pin_q) == ($past(valid_q) & $past(pin_q))));
endmodule

bind tlb_pin_cache tlb_pin_cache_chk #(.N(ENTRIES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .fill_valid(fill_valid),
  .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_err(fill_err),
  .lk_match(lk_match), .valid_q(valid_q), .pin_q(pin_q), .repl_evt(repl_evt),
  .vic_idx(vic_idx)
);

// File: tb/tlb_pin_cache_test.sv
`timescale 1ns/1ps
module tlb_pin_cache_test;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lookup_valid = 1'b0;
  logic [VW-1:0] lookup_vpn = '0;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          fill_pin = 1'b0;
  logic          flush = 1'b0;
  logic          rsp_valid, rsp_hit, fill_err;
  logic [PW-1:0] rsp_pfn;

  int checks = 0;
  int fails  = 0;

  // Reference model: per-entry state plus a last-touch timestamp.
  bit mv[N];
  bit mp[N];
  int mvpn[N];
  int mpfn[N];
  int ts[N];
  int now = 0;

  always #2.5 clk = ~clk;

  tlb_pin_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_pin(fill_pin), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pfn(rsp_pfn), .fill_err(fill_err)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit lv, input int lvpn, input bit fv, input int fvpn,
                      input int fpfn, input bit fp, input bit fl, input string tag);
    int  hidx, tgt, epfn;
    bit  eerr, accepted;
    lookup_valid = lv; lookup_vpn = VW'(lvpn);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_pfn = PW'(fpfn); fill_pin = fp;
    flush = fl;
    hidx = -1; epfn = 0; eerr = 0; accepted = 0;
    for (int i = 0; i < N; i++) if (lv && mv[i] && mvpn[i] == lvpn) hidx = i;
    if (hidx >= 0) epfn = mpfn[hidx];
    if (fl) begin
      for (int i = 0; i < N; i++) if (!mp[i]) mv[i] = 0;
    end else if (fv) begin
      tgt = -1;
      for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == fvpn) tgt = i;
      if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) tgt = i;
      if (tgt < 0) begin
        int best;
        best = -1;
        for (int i = 0; i < N; i++)
          if (mv[i] && !mp[i] && (best < 0 || ts[i] < ts[best])) best = i;
        tgt = best;
      end
      if (tgt < 0) eerr = 1;
      else begin
        mv[tgt] = 1; mp[tgt] = fp; mvpn[tgt] = fvpn; mpfn[tgt] = fpfn;
        now++; ts[tgt] = now; accepted = 1;
      end
    end
    if (!accepted && hidx >= 0) begin now++; ts[hidx] = now; end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", int'(rsp_valid), int'(lv));
    check(tag, "rsp_hit", int'(rsp_hit), (hidx >= 0) ? 1 : 0);
    check(tag, "rsp_pfn", int'(rsp_pfn), epfn);
    check(tag, "fill_err", int'(fill_err), int'(eerr));
    lookup_valid = 0; fill_valid = 0; flush = 0; fill_pin = 0;
  endtask

  task automatic look(input int v, input string tag);
    step(1, v, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input int v, input int f, input bit p, input string tag);
    step(0, 0, 1, v, f, p, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mp[i] = 0; mvpn[i] = 0; mpfn[i] = 0; ts[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    check("R1", "rsp_hit", int'(rsp_hit), 0);
    check("R1", "rsp_pfn", int'(rsp_pfn), 0);
    check("R1", "fill_err", int'(fill_err), 0);
    rst_n = 1;
    @(negedge clk);
    look(10, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R2");

    // R3: fill free slots, then hit each
    for (int k = 0; k < N; k++) fill(10 + k, 1 + k, 0, "R3");
    for (int k = 0; k < N; k++) look(10 + k, "R3");
    look(99, "R2");

    // R5: touch 10, new page evicts 11
    look(10, "R5");
    fill(20, 7, 0, "R5");
    look(11, "R5");
    check("R5", "evicted page hit", int'(rsp_hit), 0);
    look(20, "R5");

    // R4: refill of a held page updates in place
    fill(12, 9, 0, "R4");
    look(12, "R4");
    check("R4", "updated frame", int'(rsp_pfn), 9);

    // R6: pinned page survives a stream of new pages
    fill(40, 5, 1, "R6");
    for (int k = 0; k < 6; k++) fill(50 + k, 20 + k, 0, "R6");
    look(40, "R6");
    check("R6", "pinned hit", int'(rsp_hit), 1);

    // R8: flush with a same-cycle fill
    step(0, 0, 1, 60, 11, 0, 1, "R8");
    look(40, "R8");
    look(55, "R8");
    look(60, "R8");
    check("R8", "fill during flush dropped", int'(rsp_hit), 0);

    // R7: all pinned, new page rejected
    fill(61, 31, 1, "R7");
    fill(62, 32, 1, "R7");
    fill(63, 33, 1, "R7");
    fill(70, 12, 0, "R7");
    check("R7", "fill_err pulse", int'(fill_err), 1);
    look(70, "R7");
    check("R7", "err pulse width", int'(fill_err), 0);
    look(61, "R7");

    // R4: unpin by refill, then a new page may replace it
    fill(61, 34, 0, "R4");
    fill(71, 13, 0, "R4");
    look(61, "R4");

    // R9: lookup and fill of the same page in one cycle
    step(1, 62, 1, 62, 40, 1, 0, "R9");
    check("R9", "old frame seen", int'(rsp_pfn), 32);
    look(62, "R9");
    step(1, 40, 1, 72, 3, 0, 0, "R9");

    // Random sweep over a small page space (R5, R6, R7, R8 mixed)
    fill(62, 1, 0, "R5");
    fill(40, 2, 0, "R5");
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom);
      step(r[0], r[3:1] % 6, r[4], r[7:5] % 6, r[13:8], r[15:14] == 2'b11,
           r[19:16] == 4'hF, "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule